// File: doc/BRIEF.md
# Shared Pipeline Slot Front-End

This block lets a single pipelined compute unit look like several separate function units to whatever schedules work. It holds a small number of operand/result slots. Each slot takes a pair of operands, waits for a turn at the shared pipe, and later receives its own result. A round-robin arbiter sends at most one ready slot into the pipe each cycle. The number of that slot goes into the pipe beside the operands as plain payload. When the operation leaves the pipe, that number alone decides which result register is written. No ordering queue sits beside the pipe.

The compute stage is a stand-in: an unsigned add modulo 2^DATA_W. The operation takes a one-cycle shortcut path when its second operand is zero, and otherwise goes down a main path MAIN_LAT stages deep. Both paths fan out to the result slots, and their outputs are merged with OR gates. That merge is only correct if the two paths never finish in the same cycle. The arbiter holds back a shortcut operation whenever a main-path operation is one stage from the exit. A slot stays busy from the moment it is loaded until its result is acknowledged.

Top module: `fanPipeFront`

## Requirements
- R1: After reset every slot reports free (`slotFree` all ones) and no result is valid (`resValid` all zeros).
- R2: A slot accepts operands on a clock edge where its `loadValid` bit is high and the slot is free. `slotFree` for that slot then drops. Load requests and operand values presented to a slot that is not free are ignored and do not change its eventual result.
- R3: The result written to a slot equals (srcA + srcB) mod 2^DATA_W, using the operands that slot accepted. It goes to the slot that was loaded and to no other slot.
- R4: An operation whose second operand is non-zero takes the main path. When it is granted at once and nothing blocks it, its `resValid` bit rises MAIN_LAT+1 clock edges after the edge that loaded it.
- R5: An operation whose second operand is zero takes the shortcut path. When it is granted at once and nothing blocks it, its `resValid` bit rises 2 clock edges after the edge that loaded it.
- R6: At most one slot is granted per cycle. The grant goes to the first ready slot found by searching upward from a pointer, wrapping at the top. The pointer is slot 0 after reset and moves to the slot just above each grant. Four main-path operations loaded together therefore finish on four consecutive edges in grant order.
- R7: A shortcut operation is not granted in a cycle where a main-path operation is one stage from its exit. It waits one cycle instead, so at most one result is written per cycle.
- R8: A high `resAck` bit on an edge where that slot's result is valid clears `resValid` and frees the slot at that edge. `resAck` on a slot without a valid result is ignored.
- R9: While a slot's `resValid` stays high, its `resData` field does not change, even as other slots complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | SLOTS | Per-slot request to accept operands |
| srcA | input | SLOTS*DATA_W | First operand of each slot, slot i in bits [i*DATA_W +: DATA_W] |
| srcB | input | SLOTS*DATA_W | Second operand of each slot, same packing; zero selects the shortcut path |
| slotFree | output | SLOTS | Slot is idle and can accept operands |
| resValid | output | SLOTS | Slot holds a finished result |
| resData | output | SLOTS*DATA_W | Result of each slot, same packing as the operands |
| resAck | input | SLOTS | Per-slot acknowledge that releases a valid result |

## Verification
Counting the loading edge as edge zero, a result is due on edge MAIN_LAT+1 for a main-path operation and on edge 2 for a shortcut operation. An operation that has to wait for the arbiter, or for the exit-collision hold, is due that many edges later. The bench drives inputs on the falling edge and samples on the falling edge that follows each rising edge. After every edge up to the expected one it checks that `resValid` is still low, and at the expected edge it checks both the flag and the data. The tests that place several operations together work out each slot's completion edge from the grant order and the collision rule, and compare the whole `resValid` vector edge by edge.

// File: rtl/fanPipePkg.sv
package fanPipePkg;
  localparam int SLOTS    = 4;
  localparam int DATA_W   = 16;
  localparam int MAIN_LAT = 3;
  localparam int ID_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_READY,
    SLOT_BUSY,
    SLOT_DONE
  } slotState_e;

  // control -> datapath
  typedef struct packed {
    logic [SLOTS-1:0] loadEn;
    logic             issue;
    logic [ID_W-1:0]  issueId;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic [SLOTS-1:0] opEarly;
    logic [SLOTS-1:0] doneHot;
    logic             mainNearEnd;
  } dataStatus_t;
endpackage

// File: rtl/fanPipeData.sv
module fanPipeData
  import fanPipePkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [SLOTS*DATA_W-1:0]  srcA,
  input  logic [SLOTS*DATA_W-1:0]  srcB,
  output dataStatus_t              status,
  output logic [SLOTS*DATA_W-1:0]  resData
);
  logic [DATA_W-1:0] opA  [SLOTS];
  logic [DATA_W-1:0] opB  [SLOTS];
  logic [DATA_W-1:0] resQ [SLOTS];
  logic [SLOTS-1:0]  earlyVec;

  // operand latch sets
  for (genvar i = 0; i < SLOTS; i++) begin : g_opnd
    always_ff @(posedge clk) begin
      if (!rstN) begin
        opA[i] <= '0;
        opB[i] <= '0;
      end else if (strobe.loadEn[i]) begin
        opA[i] <= srcA[i*DATA_W +: DATA_W];
        opB[i] <= srcB[i*DATA_W +: DATA_W];
      end
    end
    assign earlyVec[i] = (opB[i] == '0);
  end

  // pipe entry
  logic [DATA_W-1:0] entrySum;
  logic              entryEarly;
  assign entrySum   = opA[strobe.issueId] + opB[strobe.issueId];
  assign entryEarly = earlyVec[strobe.issueId];

  // shortcut path: one stage
  logic              shortVld;
  logic [ID_W-1:0]   shortId;
  logic [DATA_W-1:0] shortRes;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shortVld <= 1'b0;
      shortId  <= '0;
      shortRes <= '0;
    end else begin
      shortVld <= strobe.issue && entryEarly;
      shortId  <= strobe.issueId;
      shortRes <= entrySum;
    end
  end

  // main path: MAIN_LAT stages, slot id carried as payload
  logic              mVld [MAIN_LAT];
  logic [ID_W-1:0]   mId  [MAIN_LAT];
  logic [DATA_W-1:0] mRes [MAIN_LAT];
  for (genvar k = 0; k < MAIN_LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mVld[k] <= 1'b0;
        mId[k]  <= '0;
        mRes[k] <= '0;
      end else if (k == 0) begin
        mVld[k] <= strobe.issue && !entryEarly;
        mId[k]  <= strobe.issueId;
        mRes[k] <= entrySum;
      end else begin
        mVld[k] <= mVld[(k > 0) ? k-1 : 0];
        mId[k]  <= mId[(k > 0) ? k-1 : 0];
        mRes[k] <= mRes[(k > 0) ? k-1 : 0];
      end
    end
  end

  logic nearEnd;
  if (MAIN_LAT >= 2) begin : g_near
    assign nearEnd = mVld[MAIN_LAT-2];
  end else begin : g_noNear
    assign nearEnd = 1'b0;
  end

  // two fan-outs, merged by OR
  logic [SLOTS-1:0]  shortHot, mainHot, writeHot;
  logic [DATA_W-1:0] mergedRes;
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      shortHot[i] = shortVld && (shortId == ID_W'(i));
      mainHot[i]  = mVld[MAIN_LAT-1] && (mId[MAIN_LAT-1] == ID_W'(i));
    end
    writeHot  = shortHot | mainHot;
    mergedRes = ({DATA_W{shortVld}} & shortRes)
              | ({DATA_W{mVld[MAIN_LAT-1]}} & mRes[MAIN_LAT-1]);
  end

  // result latch sets
  for (genvar i = 0; i < SLOTS; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN)            resQ[i] <= '0;
      else if (writeHot[i]) resQ[i] <= mergedRes;
    end
    assign resData[i*DATA_W +: DATA_W] = resQ[i];
  end

  assign status.opEarly     = earlyVec;
  assign status.doneHot     = writeHot;
  assign status.mainNearEnd = nearEnd;
endmodule

// File: rtl/fanPipeCtrl.sv
module fanPipeCtrl
  import fanPipePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] loadValid,
  input  logic [SLOTS-1:0] resAck,
  input  dataStatus_t      status,
  output ctrlStrobe_t      strobe,
  output logic [SLOTS-1:0] slotFree,
  output logic [SLOTS-1:0] resValid
);
  slotState_e       slotSt [SLOTS];
  logic [ID_W-1:0]  rrPtr;
  logic [SLOTS-1:0] eligible, grantHot, loadHot;
  logic             found;
  logic [ID_W-1:0]  pick;

  for (genvar i = 0; i < SLOTS; i++) begin : g_flags
    assign slotFree[i] = (slotSt[i] == SLOT_IDLE);
    assign resValid[i] = (slotSt[i] == SLOT_DONE);
    assign loadHot[i]  = loadValid[i] && slotFree[i];
    assign eligible[i] = (slotSt[i] == SLOT_READY)
                       && !(status.opEarly[i] && status.mainNearEnd);
  end

  // round-robin search from rrPtr
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < SLOTS; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % SLOTS;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = ID_W'(idx);
      end
    end
    for (int i = 0; i < SLOTS; i++) begin
      grantHot[i] = found && (pick == ID_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (found) begin
      rrPtr <= (int'(pick) == SLOTS-1) ? '0 : pick + 1'b1;
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_state
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotSt[i] <= SLOT_IDLE;
      end else begin
        case (slotSt[i])
          SLOT_IDLE:  if (loadHot[i])        slotSt[i] <= SLOT_READY;
          SLOT_READY: if (grantHot[i])       slotSt[i] <= SLOT_BUSY;
          SLOT_BUSY:  if (status.doneHot[i]) slotSt[i] <= SLOT_DONE;
          SLOT_DONE:  if (resAck[i])         slotSt[i] <= SLOT_IDLE;
          default:                           slotSt[i] <= SLOT_IDLE;
        endcase
      end
    end
  end

  assign strobe.loadEn  = loadHot;
  assign strobe.issue   = found;
  assign strobe.issueId = pick;
endmodule

// File: rtl/fanPipeFront.sv
module fanPipeFront
  import fanPipePkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SLOTS-1:0]        loadValid,
  input  logic [SLOTS*DATA_W-1:0] srcA,
  input  logic [SLOTS*DATA_W-1:0] srcB,
  output logic [SLOTS-1:0]        slotFree,
  output logic [SLOTS-1:0]        resValid,
  output logic [SLOTS*DATA_W-1:0] resData,
  input  logic [SLOTS-1:0]        resAck
);
  ctrlStrobe_t      strobeBus;
  dataStatus_t      statusBus;
  logic [SLOTS-1:0] doneHot;

  fanPipeCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .loadValid(loadValid),
    .resAck   (resAck),
    .status   (statusBus),
    .strobe   (strobeBus),
    .slotFree (slotFree),
    .resValid (resValid)
  );

  fanPipeData data_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobeBus),
    .srcA   (srcA),
    .srcB   (srcB),
    .status (statusBus),
    .resData(resData)
  );

  assign doneHot = statusBus.doneHot;
endmodule

// File: rtl/fanPipeChk.sv
module fanPipeChk
  import fanPipePkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [SLOTS-1:0]        loadValid,
  input logic [SLOTS-1:0]        slotFree,
  input logic [SLOTS-1:0]        resValid,
  input logic [SLOTS*DATA_W-1:0] resData,
  input logic [SLOTS-1:0]        resAck,
  input logic [SLOTS-1:0]        doneHot
);
  // R7
  single_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneHot));

  // R2
  free_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(slotFree) & ~slotFree & ~$past(loadValid)) == '0));

  // R4
  rise_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((resValid & ~$past(resValid) & $past(slotFree)) == '0));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((resValid & $past(resValid & resAck)) == '0));

  for (genvar i = 0; i < SLOTS; i++) begin : g_hold
    // R9
    hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
      (resValid[i] && $past(resValid[i])) |-> $stable(resData[i*DATA_W +: DATA_W]));
  end
endmodule

bind fanPipeFront fanPipeChk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .loadValid(loadValid),
  .slotFree (slotFree),
  .resValid (resValid),
  .resData  (resData),
  .resAck   (resAck),
  .doneHot  (doneHot)
);

// File: tb/fanPipeFront_tb.sv
module fanPipeFront_tb_top;
  import fanPipePkg::*;
  localparam int CLK_PERIOD = 10;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [SLOTS-1:0]        loadValid = '0;
  logic [SLOTS*DATA_W-1:0] srcA = '0;
  logic [SLOTS*DATA_W-1:0] srcB = '0;
  logic [SLOTS-1:0]        slotFree;
  logic [SLOTS-1:0]        resValid;
  logic [SLOTS*DATA_W-1:0] resData;
  logic [SLOTS-1:0]        resAck = '0;

  int checkCnt = 0;
  int errCnt   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fanPipeFront dut_i (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .srcA(srcA), .srcB(srcB),
    .slotFree(slotFree), .resValid(resValid), .resData(resData), .resAck(resAck)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] dataOf(input int s);
    return resData[s*DATA_W +: DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] sumOf(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    return DATA_W'(a + b);
  endfunction

  task automatic setOps(input int s, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    srcA[s*DATA_W +: DATA_W] = a;
    srcB[s*DATA_W +: DATA_W] = b;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one operation alone; stray loads and acks held during flight
  task automatic runSingle(input int s, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    int lat;
    lat = (b == '0) ? 2 : MAIN_LAT + 1;
    setOps(s, a, b);
    loadValid[s] = 1'b1;
    tick();
    check(slotFree[s] == 1'b0, "R2 slot taken", slotFree[s], 0);
    setOps(s, ~a, ~b);          // R2: must be ignored
    resAck[s] = 1'b1;           // R8: must be ignored while not done
    for (int k = 1; k <= lat; k++) begin
      if (k == lat - 1 || lat == 1) begin
        loadValid[s] = 1'b0;
      end
      if (k == lat) begin
        resAck[s] = 1'b0;
        loadValid[s] = 1'b0;
      end
      if (k == lat - 1) resAck[s] = 1'b0;
      tick();
      if (k < lat) begin
        check(resValid[s] == 1'b0, (b == '0) ? "R5 not early" : "R4 not early", resValid[s], 0);
      end else begin
        check(resValid[s] == 1'b1, (b == '0) ? "R5 latency" : "R4 latency", resValid[s], 1);
        check(dataOf(s) == sumOf(a, b), "R3 value", dataOf(s), sumOf(a, b));
        check(resValid == (SLOTS'(1) << s), "R3 routed slot", resValid, SLOTS'(1) << s);
      end
    end
    resAck[s] = 1'b1;
    tick();
    resAck[s] = 1'b0;
    check(resValid[s] == 1'b0 && slotFree[s] == 1'b1, "R8 ack release", {resValid[s], slotFree[s]}, 2'b01);
  endtask

  task automatic ackAll();
    resAck = '1;
    tick();
    resAck = '0;
    check(slotFree == '1, "R8 all free", slotFree, {SLOTS{1'b1}});
  endtask

  logic [DATA_W-1:0] aList [5] = '{16'h0000, 16'h0001, 16'h7fff, 16'hffff, 16'h1234};
  logic [DATA_W-1:0] bList [4] = '{16'h0000, 16'h0001, 16'hffff, 16'h00ff};

  initial begin
    logic [SLOTS-1:0] expMask;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    check(slotFree == '1, "R1 free after reset", slotFree, {SLOTS{1'b1}});
    check(resValid == '0, "R1 no result after reset", resValid, 0);

    // R2 R3 R4 R5 R8 sweep
    for (int s = 0; s < SLOTS; s++) begin
      for (int ai = 0; ai < 5; ai++) begin
        for (int bi = 0; bi < 4; bi++) begin
          runSingle(s, aList[ai], bList[bi]);
        end
      end
    end

    // R6: pointer at 0 after the sweep (last grant was slot 3)
    for (int s = 0; s < SLOTS; s++) setOps(s, DATA_W'(10 * s + 1), DATA_W'(s + 2));
    loadValid = '1;
    tick();
    loadValid = '0;
    for (int k = 1; k <= MAIN_LAT + SLOTS; k++) begin
      tick();
      expMask = '0;
      for (int s = 0; s < SLOTS; s++) if (MAIN_LAT + 1 + s <= k) expMask[s] = 1'b1;
      check(resValid == expMask, "R6 grant order", resValid, expMask);
    end
    // R9: slot 0 result unchanged while others completed
    check(dataOf(0) == sumOf(1, 2), "R9 held data", dataOf(0), sumOf(1, 2));
    for (int s = 1; s < SLOTS; s++)
      check(dataOf(s) == sumOf(DATA_W'(10 * s + 1), DATA_W'(s + 2)), "R3 batch value",
            dataOf(s), sumOf(DATA_W'(10 * s + 1), DATA_W'(s + 2)));
    ackAll();

    // R6: grant slot 1 alone -> pointer moves to 2
    runSingle(1, 16'h0003, 16'h0004);
    setOps(0, 16'h0100, 16'h0001);
    setOps(3, 16'h0300, 16'h0001);
    loadValid = 4'b1001;
    tick();
    loadValid = '0;
    for (int k = 1; k <= MAIN_LAT + 2; k++) begin
      tick();
      expMask = '0;
      if (k >= MAIN_LAT + 1) expMask[3] = 1'b1;
      if (k >= MAIN_LAT + 2) expMask[0] = 1'b1;
      check(resValid == expMask, "R6 wrap from pointer", resValid, expMask);
    end
    ackAll();

    // R7: shortcut op must wait while the main op is one stage from exit
    setOps(0, 16'h0003, 16'h0004);
    loadValid = 4'b0001;
    tick();                      // edge 0
    loadValid = '0;
    tick();                      // edge 1: slot 0 issued
    setOps(1, 16'h0009, 16'h0000);
    loadValid = 4'b0010;
    tick();                      // edge 2: slot 1 loaded
    loadValid = '0;
    tick();                      // edge 3: slot 1 held back
    check(resValid == 4'b0000, "R7 none yet", resValid, 0);
    tick();                      // edge 4: main result
    check(resValid == 4'b0001, "R7 main first", resValid, 4'b0001);
    tick();                      // edge 5: shortcut result
    check(resValid == 4'b0011, "R7 shortcut delayed", resValid, 4'b0011);
    check(dataOf(0) == 16'h0007, "R7 main value", dataOf(0), 16'h0007);
    check(dataOf(1) == 16'h0009, "R7 shortcut value", dataOf(1), 16'h0009);
    ackAll();

    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end
endmodule